// File: doc/BRIEF.md
# Multi-Channel Servo Pulse Generator

This block drives a bank of hobby servos, with one output pin per channel. Software sets each servo's position by writing a word into that channel's position register, through a simple byte-addressed register port. Every output rises together at the start of a shared frame. Each output then stays high for a time set by its position. The time runs linearly from a minimum pulse width at position 0 to a maximum at position 255.

All timing comes from nanosecond parameters and the clock period. A divider turns the clock into a step tick, with STEP_CYC = max(1, (MAX_NS - MIN_NS) / (255 * CLK_NS)) clock cycles per step. From the step length follow the base width MIN_STEPS = MIN_NS / (STEP_CYC * CLK_NS) and the frame length FRAME_STEPS = FRAME_NS / (STEP_CYC * CLK_NS). FRAME_STEPS is raised to MIN_STEPS + 256 if it would otherwise be shorter. A position written mid-frame is held back until the next frame begins, so a running pulse keeps its width.

Top module: `servo_pwm_bank`

## Requirements
- R1: While reset is asserted and directly after it, every output is low and every position register reads back 128.
- R2: The register for channel i (0-based) sits at byte address 8 + 4*i. A read there returns exactly the 32-bit value last written.
- R3: A write to any address that is not a channel register changes no register and no pulse width. A read of such an address returns 0.
- R4: All outputs rise in the same clock cycle. Successive rises are FRAME_STEPS * STEP_CYC cycles apart.
- R5: A channel with position p (0 to 255) stays high for (MIN_STEPS + p) * STEP_CYC cycles in each frame.
- R6: A position above 255, including one whose upper bits are set, gives the same width as 255. The register still reads back the full written value.
- R7: A position written during a frame leaves that frame's pulse unchanged and takes effect from the next frame.
- R8: After reset is released, the first frame starts within STEP_CYC clock cycles. Until then every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Byte address of the combinational read |
| rd_data | output | 32 | Read data |
| pwm_o | output | NUM_CH | Servo pulse outputs, one per channel |

## Verification
The hardest case to reach from the ports is a position change that arrives while a pulse is still high. This case must change the next frame and leave the current one alone. The stimulus lines up on an observed rising edge and issues the write a few cycles into the pulse. It then measures the current pulse and the following pulse separately. Random positions, including values past 255, are written in the low part of frames, and each following frame's widths are compared with the width formula. Writes to addresses next to and just past the register window check that nothing changes.

// File: rtl/servo_pwm_bank.sv
module servo_pwm_bank #(
  parameter int NUM_CH   = 4,
  parameter int AW       = 8,
  parameter int CLK_NS   = 8,
  parameter int MIN_NS   = 1_000_000,
  parameter int MAX_NS   = 2_000_000,
  parameter int FRAME_NS = 20_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [31:0]       rd_data,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int STEP_RAW    = (MAX_NS - MIN_NS) / (255 * CLK_NS);
  localparam int STEP_CYC    = (STEP_RAW < 1) ? 1 : STEP_RAW;
  localparam int TICK_NS     = STEP_CYC * CLK_NS;
  localparam int MIN_STEPS   = MIN_NS / TICK_NS;
  localparam int FRAME_RAW   = FRAME_NS / TICK_NS;
  localparam int FRAME_STEPS = (FRAME_RAW > MIN_STEPS + 256) ? FRAME_RAW : MIN_STEPS + 256;
  localparam int DW          = $clog2(STEP_CYC + 1);
  localparam int FW          = $clog2(FRAME_STEPS + 1);
  localparam int BASE        = 8;

  logic [DW-1:0]                div_q;
  logic [FW-1:0]                fcnt_q;
  logic                         started_q;
  logic [NUM_CH-1:0][31:0]      pos_q;
  logic [NUM_CH-1:0][7:0]       act_q;
  logic                         tick, bound;

  assign tick  = (div_q == DW'(STEP_CYC - 1));
  assign bound = tick && (fcnt_q == FW'(FRAME_STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      fcnt_q    <= FW'(FRAME_STEPS - 1);
      started_q <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (bound) begin
        fcnt_q    <= '0;
        started_q <= 1'b1;
      end else if (tick) begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q[i] <= 32'd128;
        act_q[i] <= 8'd128;
      end else begin
        if (wr_en && wr_addr == AW'(BASE + 4 * i)) pos_q[i] <= wr_data;
        if (bound) act_q[i] <= (|pos_q[i][31:8]) ? 8'hFF : pos_q[i][7:0];
      end
    end
    assign pwm_o[i] = started_q && (fcnt_q < FW'(MIN_STEPS) + FW'(act_q[i]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_addr == AW'(BASE + 4 * i)) rd_data = pos_q[i];
  end
endmodule

// File: rtl/servo_pwm_bank_chk.sv
module servo_pwm_bank_chk #(
  parameter int N         = 4,
  parameter int AW        = 8,
  parameter int FW        = 8,
  parameter int MIN_STEPS = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         pwm_o,
  input logic                 started,
  input logic [FW-1:0]        fcnt,
  input logic                 bound,
  input logic                 wr_en,
  input logic [AW-1:0]        wr_addr,
  input logic [N-1:0][31:0]   pos,
  input logic [N-1:0][7:0]    act
);
  logic addr_ok;
  assign addr_ok = (wr_addr >= AW'(8)) && (wr_addr < AW'(8 + 4 * N)) && (wr_addr[1:0] == 2'b00);

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !started |-> pwm_o == '0);
  // R4
  joint_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwm_o) == '0 && pwm_o != '0) |-> (&pwm_o));
  // R5
  base_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && fcnt < FW'(MIN_STEPS)) |-> (&pwm_o));
  // R6
  ceiling_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt >= FW'(MIN_STEPS + 255)) |-> pwm_o == '0);
  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !bound |=> $stable(act));
  // R3
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_ok) |=> $stable(pos));
endmodule

bind servo_pwm_bank servo_pwm_bank_chk #(
  .N(NUM_CH), .AW(AW), .FW(FW), .MIN_STEPS(MIN_STEPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .started(started_q), .fcnt(fcnt_q),
  .bound(bound), .wr_en(wr_en), .wr_addr(wr_addr), .pos(pos_q), .act(act_q)
);

// File: tb/tb_servo_pwm_bank.sv
module tb_servo_pwm_bank;
  localparam int NCH = 4, AW = 8, CLK_NS = 8;
  localparam int MIN_NS = 160, MAX_NS = 4240, FRAME_NS = 4800;
  localparam int STEP = 2, MINS = 10, FRAMES = 300;
  localparam int PERIOD = FRAMES * STEP;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NCH-1:0] pwm_o;

  int compared = 0, mismatched = 0;
  longint cyc = 0, last_rise = -1;
  int hw [NCH];
  logic [31:0] model [NCH];

  servo_pwm_bank #(.NUM_CH(NCH), .AW(AW), .CLK_NS(CLK_NS), .MIN_NS(MIN_NS),
    .MAX_NS(MAX_NS), .FRAME_NS(FRAME_NS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_w(logic [31:0] p);
    return (MINS + ((p > 32'd255) ? 255 : int'(p))) * STEP;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic check_regs(string tag);
    logic [31:0] d;
    for (int i = 0; i < NCH; i++) begin
      rd(AW'(8 + 4 * i), d);
      chk(tag, d, model[i]);
    end
  endtask

  task automatic sync_rise();
    int n = 0;
    while (pwm_o != '0 && n < 2000) begin @(negedge clk); n++; end
    while (pwm_o == '0 && n < 2000) begin @(negedge clk); n++; end
    chk("R4 joint rise", pwm_o, {NCH{1'b1}});
    if (last_rise >= 0) chk("R4 period", cyc - last_rise, PERIOD);
    last_rise = cyc;
  endtask

  task automatic count_high(int wr_at, logic [AW-1:0] a, logic [31:0] d);
    int k = 0;
    for (int i = 0; i < NCH; i++) hw[i] = pwm_o[i] ? 1 : 0;
    while (pwm_o != '0 && k < 2000) begin
      if (k == wr_at) begin wr_en = 1; wr_addr = a; wr_data = d; end
      else wr_en = 0;
      @(negedge clk);
      k++;
      for (int i = 0; i < NCH; i++) if (pwm_o[i]) hw[i]++;
    end
    wr_en = 0;
  endtask

  task automatic frame_check(string tag);
    sync_rise();
    count_high(-1, '0, '0);
    for (int i = 0; i < NCH; i++) chk(tag, hw[i], exp_w(model[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd2718));
    for (int i = 0; i < NCH; i++) model[i] = 32'd128;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outputs low", pwm_o, 0);
    check_regs("R1 midpoint");
    rst_n = 1;
    // R8 first frame start
    n = 0;
    while (pwm_o == '0 && n < 50) begin @(negedge clk); n++; end
    chk("R8 start within step", (n >= 1 && n <= STEP) ? 1 : 0, 1);
    last_rise = cyc;
    count_high(-1, '0, '0);
    for (int i = 0; i < NCH; i++) chk("R5 midpoint width", hw[i], exp_w(128));

    // R2 R6 directed extremes
    model[0] = 0; model[1] = 255; model[2] = 300; model[3] = 32'hFFFF_FFFF;
    for (int i = 0; i < NCH; i++) wr(AW'(8 + 4 * i), model[i]);
    check_regs("R2 readback");
    frame_check("R6 clamp and R5 width");

    // R3 stray addresses
    wr(8'h00, 32'd7); wr(8'h04, 32'd7); wr(8'h09, 32'd7); wr(AW'(8 + 4 * NCH), 32'd7);
    check_regs("R3 regs unchanged");
    rd(8'h04, d); chk("R3 stray read", d, 0);
    rd(AW'(8 + 4 * NCH), d); chk("R3 stray read", d, 0);
    frame_check("R3 widths unchanged");

    // R7 mid-pulse update
    sync_rise();
    count_high(5, 8'h0C, 32'd50);
    chk("R7 current pulse kept", hw[1], exp_w(255));
    model[1] = 50;
    frame_check("R7 next frame");

    // random positions
    for (int it = 0; it < 6; it++) begin
      for (int i = 0; i < NCH; i++) begin
        model[i] = $urandom % 320;
        wr(AW'(8 + 4 * i), model[i]);
      end
      check_regs("R2 random readback");
      frame_check("R5 random width");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule